// File: doc/BRIEF.md
# Dual-Channel Programmable Clock Divider

Two clock-output channels share one 32-bit control word. Each channel takes one of two single-cycle tick enables and divides it by a ratio from 1 to 16. A compare threshold shapes the output waveform. The output is high for the first part of each period and low for the rest. Everything runs in the system clock domain, and each output is a level that a downstream clock-generation stage can use.

Software writes the control word through a one-cycle write strobe and reads it back at any time. When a write changes a channel's divide field, the block rewrites that channel's compare field in the next cycle to give a duty cycle as close to half as the ratio allows. A later write that keeps the divide field unchanged can set any other threshold directly. New ratio, compare and source settings are held back until the running period ends, so a change never cuts a pulse short.

Top module: `clkdiv_pair`

## Requirements
- R1: While reset is asserted, and after it is released, the control word reads 0 and both outputs are low.
- R2: Channel c (0 or 1) owns bits 16c to 16c+11 of the control word. Bit 16c is the enable, bit 16c+1 is the source select, bits 16c+7:16c+4 hold the divide field D, and bits 16c+11:16c+8 hold the compare field C. The ratio is N = D+1.
- R3: If a write changes channel c's divide field, the control word reads C = ((N+1) div 2) - 1 from the second cycle after the strobe. In the first cycle it reads the written value. For example, N=4 gives 1, N=5 gives 2 and N=16 gives 7.
- R4: The automatic update changes only that channel's 4-bit compare field. Every other bit of the word, unused bits included, keeps its written value.
- R5: A write that leaves a channel's divide field unchanged keeps the compare value written by software.
- R6: With N>1, a channel counts ticks on its selected source from 0 to N-1 and then wraps. Its output is high while the count is at or below C and low otherwise.
- R7: While a channel's enable is 0, its output is low and its count is held at 0. Setting the enable starts the waveform at count 0 with the output high.
- R8: Source select 0 takes tick input 0 and select 1 takes tick input 1. Ticks on the unselected input do not advance the count.
- R9: With N=1, an enabled channel's output equals its selected tick input.
- R10: A new divide, compare or source value written while a channel runs takes effect only after the current period wraps.
- R11: The two channels run independently, each with its own ratio, threshold and source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_tick_i | input | 2 | Single-cycle tick enables of the two sources |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Control word to write |
| rd_data_o | output | 32 | Current control word |
| div_clk_o | output | 2 | Divided output of each channel |

## Verification
The assertions assume that the tick inputs and the write strobe are synchronous to clk_i. They also assume that the settled control word is what a channel reloads at a wrap. The only write they expect in the cycle after a divide change is one that supersedes the pending update. The stimulus drives every input on the falling edge and spaces writes at least two cycles apart, so each automatic update completes before the next write. It pauses the ticks while reconfiguring, so the count at which a new setting lands is known exactly.

// File: rtl/clkdiv_pair_pkg.sv
package clkdiv_pair_pkg;
  localparam int DIV_W     = 4;
  localparam int CH_STRIDE = 16;
  localparam int EN_OFS    = 0;
  localparam int SEL_OFS   = 1;
  localparam int DIV_OFS   = 4;
  localparam int CMP_OFS   = 8;
  localparam int NUM_SRC   = 2;

  typedef struct packed {
    logic             en;
    logic             sel;
    logic [DIV_W-1:0] div;
    logic [DIV_W-1:0] cmp;
  } ch_cfg_t;

  // ceil(N/2)-1 with N = div+1, i.e. ((div+2)>>1)-1
  function automatic logic [DIV_W-1:0] half_cmp(input logic [DIV_W-1:0] div_f);
    logic [DIV_W:0] sum;
    sum = {1'b0, div_f} + (DIV_W+1)'(2);
    return sum[DIV_W:1] - 1'b1;
  endfunction
endpackage

// File: rtl/clkdiv_pair_regs.sv
module clkdiv_pair_regs
  import clkdiv_pair_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int REG_W = NUM_CH * CH_STRIDE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] reg_o
);
  localparam int TAIL_W = CH_STRIDE - CMP_OFS - DIV_W;

  logic [REG_W-1:0]  reg_q;
  logic [NUM_CH-1:0] upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q <= '0;
      upd_q <= '0;
    end else if (wr_en_i) begin
      // a write always wins; a pending recompute is dropped and re-armed if needed
      reg_q <= wr_data_i;
      for (int ch = 0; ch < NUM_CH; ch++)
        upd_q[ch] <= wr_data_i[ch*CH_STRIDE+DIV_OFS +: DIV_W] !=
                     reg_q[ch*CH_STRIDE+DIV_OFS +: DIV_W];
    end else begin
      for (int ch = 0; ch < NUM_CH; ch++)
        if (upd_q[ch])
          reg_q[ch*CH_STRIDE+CMP_OFS +: DIV_W] <=
            half_cmp(reg_q[ch*CH_STRIDE+DIV_OFS +: DIV_W]);
      upd_q <= '0;
    end
  end

  assign reg_o = reg_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    localparam int B = g * CH_STRIDE;

    assert_auto_cmp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_q[g] && !wr_en_i) |=>
        (reg_q[B+CMP_OFS +: DIV_W] == half_cmp(reg_q[B+DIV_OFS +: DIV_W])));

    assert_keep_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable(reg_q[B +: CMP_OFS]));

    assert_keep_tail_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable(reg_q[B+CMP_OFS+DIV_W +: TAIL_W]));
  end
endmodule

// File: rtl/clkdiv_pair_chan.sv
module clkdiv_pair_chan
  import clkdiv_pair_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  ch_cfg_t            cfg_i,
  input  logic [NUM_SRC-1:0] tick_i,
  output logic               clk_o
);
  logic [DIV_W-1:0] cnt_q, div_q, cmp_q;
  logic             sel_q;
  logic             tick, wrap;

  assign tick = tick_i[sel_q];
  assign wrap = (cnt_q == div_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= '0;
      cmp_q <= '0;
      sel_q <= 1'b0;
    end else if (!cfg_i.en) begin
      // idle: track settings so enabling starts with current values
      cnt_q <= '0;
      div_q <= cfg_i.div;
      cmp_q <= cfg_i.cmp;
      sel_q <= cfg_i.sel;
    end else if (tick) begin
      if (wrap) begin
        cnt_q <= '0;
        div_q <= cfg_i.div;
        cmp_q <= cfg_i.cmp;
        sel_q <= cfg_i.sel;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // ratio one: pass the tick straight through
  assign clk_o = cfg_i.en & ((div_q == '0) ? tick : (cnt_q <= cmp_q));

  assert_cnt_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= div_q);

  assert_off_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.en |=> (cnt_q == '0));

  assert_off_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.en |-> !clk_o);

  assert_defer_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.en && !(tick && wrap)) |=> ($stable(div_q) && $stable(cmp_q) && $stable(sel_q)));
endmodule

// File: rtl/clkdiv_pair.sv
module clkdiv_pair
  import clkdiv_pair_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int REG_W = NUM_CH * CH_STRIDE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic               wr_en_i,
  input  logic [REG_W-1:0]   wr_data_i,
  output logic [REG_W-1:0]   rd_data_o,
  output logic [NUM_CH-1:0]  div_clk_o
);
  logic [REG_W-1:0] ctrl;

  clkdiv_pair_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .reg_o     (ctrl)
  );

  assign rd_data_o = ctrl;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int B = g * CH_STRIDE;
    ch_cfg_t cfg;

    assign cfg.en  = ctrl[B+EN_OFS];
    assign cfg.sel = ctrl[B+SEL_OFS];
    assign cfg.div = ctrl[B+DIV_OFS +: DIV_W];
    assign cfg.cmp = ctrl[B+CMP_OFS +: DIV_W];

    clkdiv_pair_chan u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cfg_i  (cfg),
      .tick_i (src_tick_i),
      .clk_o  (div_clk_o[g])
    );
  end
endmodule

// File: tb/clkdiv_pair_bench.sv
module clkdiv_pair_bench;
  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  tick = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [1:0]  dclk;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  clkdiv_pair u_clkdiv_pair (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .src_tick_i (tick),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .rd_data_o  (rd_data),
    .div_clk_o  (dclk)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int ch, bit en, bit sel, int div, int cmp);
    logic [15:0] h;
    h = '0;
    h[0] = en;
    h[1] = sel;
    h[7:4] = div[3:0];
    h[11:8] = cmp[3:0];
    return (ch != 0) ? {h, 16'h0} : {16'h0, h};
  endfunction

  function automatic int hc(int div);
    return ((div + 2) / 2) - 1;
  endfunction

  task automatic wr(logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle_all();
    tick = '0;
    wr(32'h0);
    repeat (2) @(negedge clk);
  endtask

  // configure disabled, force exact cmp, then enable; ends at a negedge with count 0
  task automatic start(logic [31:0] w);
    logic [31:0] off;
    off = w & ~32'h0001_0001;
    wr(off);
    repeat (2) @(negedge clk);
    wr(off);
    @(negedge clk);
    wr(w);
    @(negedge clk);
    check("R5", rd_data, w);
  endtask

  task automatic expect_seq(int ch, int n, int cmp, int st, int samples, string req);
    for (int k = 0; k < samples; k++) begin
      int c;
      c = (st + k) % n;
      check(req, 32'(dclk[ch]), 32'(c <= cmp));
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", rd_data, 32'h0);
    check("R1", 32'(dclk), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", rd_data, 32'h0);
    check("R1", 32'(dclk), 32'h0);
  endtask

  task automatic t_auto_cmp();
    logic [31:0] a, b, exp_b;
    a = mk(0, 0, 0, 3, 9) | mk(1, 0, 1, 9, 0);
    wr(a);
    check("R3", rd_data, a);
    @(negedge clk);
    check("R3", rd_data, mk(0, 0, 0, 3, 1) | mk(1, 0, 1, 9, hc(9)));
    // ch0 divide changes, ch1 divide unchanged with direct cmp, junk in unused bits
    b = mk(0, 0, 1, 4, 10) | mk(1, 0, 1, 9, 3) | 32'hA00C_500C;
    wr(b);
    check("R2", rd_data, b);
    @(negedge clk);
    exp_b = (b & ~32'h0000_0F00) | 32'h0000_0200;
    check("R4", rd_data, exp_b);
    check("R5", rd_data[27:24], 32'd3);
    wr(mk(1, 0, 0, 15, 0));
    @(negedge clk);
    check("R3", rd_data, mk(1, 0, 0, 15, 7));
    wr(mk(0, 0, 0, 4, 0));
    @(negedge clk);
    check("R3", rd_data, mk(0, 0, 0, 4, 2));
    idle_all();
  endtask

  task automatic t_wave();
    start(mk(0, 1, 0, 3, 1));
    tick = 2'b01;
    expect_seq(0, 4, 1, 0, 12, "R6");
    idle_all();
    start(mk(0, 1, 0, 4, 2));
    tick = 2'b01;
    expect_seq(0, 5, 2, 0, 10, "R6");
    idle_all();
    start(mk(0, 1, 0, 5, 0));
    tick = 2'b01;
    expect_seq(0, 6, 0, 0, 12, "R6");
    idle_all();
  endtask

  task automatic t_enable();
    start(mk(0, 1, 0, 3, 1));
    tick = 2'b01;
    expect_seq(0, 4, 1, 0, 6, "R7");
    tick = 2'b00;
    wr(mk(0, 0, 0, 3, 1));
    tick = 2'b01;
    for (int k = 0; k < 4; k++) begin
      check("R7", 32'(dclk[0]), 32'h0);
      @(negedge clk);
    end
    tick = 2'b00;
    wr(mk(0, 1, 0, 3, 1));
    tick = 2'b01;
    expect_seq(0, 4, 1, 0, 8, "R7");
    idle_all();
  endtask

  task automatic t_src();
    start(mk(0, 1, 1, 3, 0));
    tick = 2'b01;
    for (int k = 0; k < 4; k++) begin
      check("R8", 32'(dclk[0]), 32'h1);
      @(negedge clk);
    end
    tick = 2'b10;
    expect_seq(0, 4, 0, 0, 8, "R8");
    idle_all();
  endtask

  task automatic t_ratio_one();
    start(mk(1, 1, 0, 0, 0));
    for (int k = 0; k < 9; k++) begin
      tick[0] = (k % 3 == 0);
      tick[1] = k[0];
      #1;
      check("R9", 32'(dclk[1]), 32'(tick[0]));
      @(negedge clk);
    end
    idle_all();
  endtask

  task automatic t_defer();
    start(mk(0, 1, 0, 3, 1));
    tick = 2'b01;
    expect_seq(0, 4, 1, 0, 1, "R10");
    tick = 2'b00;
    wr(mk(0, 1, 0, 1, 0));
    repeat (2) @(negedge clk);
    check("R10", rd_data, mk(0, 1, 0, 1, 0));
    tick = 2'b01;
    expect_seq(0, 4, 1, 1, 3, "R10");
    expect_seq(0, 2, 0, 0, 4, "R10");
    idle_all();
  endtask

  task automatic t_indep();
    start(mk(0, 1, 0, 3, 1) | mk(1, 1, 0, 2, 1));
    tick = 2'b01;
    for (int k = 0; k < 12; k++) begin
      check("R11", 32'(dclk[0]), 32'((k % 4) <= 1));
      check("R11", 32'(dclk[1]), 32'((k % 3) <= 1));
      @(negedge clk);
    end
    idle_all();
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_auto_cmp();
    t_wave();
    t_enable();
    t_src();
    t_ratio_one();
    t_defer();
    t_indep();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule